// File: doc/BRIEF.md
# Dual-Bank Write Posting Buffer

This block sits on the write path of a bus bridge. Words written by the initiating bus are posted into one of two storage banks. Meanwhile the other bank, once it is sealed, is written out to the target bus. Bank 0 takes the first words. When a bank has received `DEPTH` words, or a word flagged as the last of a burst, it is sealed. From then on it accepts nothing until every word it holds has been sent out, and further input goes to the other bank. The input side is stalled whenever the bank it would write next is still sealed.

Outbound transfer needs ownership of the target bus. The drain side handles one bank at a time and alternates strictly between the two, so words leave in the order they arrived. A drain state machine waits in `DR_IDLE` until the bank it owns is sealed. It moves to `DR_REQUEST` and raises the bus request, then waits for the grant. It enters `DR_STREAM` when the grant arrives. If the grant is withdrawn, the machine falls back from `DR_STREAM` to `DR_REQUEST` at the same word. After the final beat of the bank it returns from `DR_STREAM` to `DR_IDLE`, frees that bank and moves to the other one.

A bank that is partly filled but not flagged last is never drained early: the drain side stays in `DR_IDLE` until that bank is sealed. Each bank passes through three states. Its first write moves it from `BANK_EMPTY` to `BANK_FILLING`. A write that seals it moves it to `BANK_SEALED`. When the drain side frees it, it returns to `BANK_EMPTY`.

Top module: `wpost_dual_bank`

## Requirements
- R1: While reset is active, and in the first cycle after it, `bus_req`, `out_valid` and `in_stall` are all 0.
- R2: The first accepted word goes to bank 0. A bank is sealed by its `DEPTH`-th accepted word, and later words go to the other bank.
- R3: `bus_req` rises on the second rising edge after the write that seals a bank, whether or not `bus_grant` is present.
- R4: `out_valid` is 1 only while `bus_grant` is 1 and the draining bank is sealed. Words leave in the exact order they were accepted.
- R5: A sealed bank accepts no writes until its last word has been sent. Once emptied it accepts the next group, and `in_stall` is low again.
- R6: Once a bank has been drained, the other bank is drained only after it is sealed. While that bank is partly filled and not flagged last, `bus_req` and `out_valid` stay 0 and its words are held.
- R7: When both banks are sealed, `in_stall` is 1 and no input word is accepted.
- R8: An accepted word with `in_last`=1 seals its bank at any fill level from 1 to `DEPTH`, so a short final burst is sent.
- R9: `bus_req` stays 1 from the moment it rises until the last word of that bank is sent, even without a grant. It is 0 when no bank is sealed.
- R10: If `bus_grant` falls during a transfer, `out_valid` drops at once and `bus_req` stays 1. When the grant returns, the transfer resumes at the first unsent word.
- R11: While `out_ready` is 0, the word on `out_data` and the queue position are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DATA_W | Posted write word |
| in_valid | input | 1 | `in_data` is offered |
| in_last | input | 1 | Offered word ends the burst and seals its bank |
| in_stall | output | 1 | Input word is not taken this cycle |
| bus_grant | input | 1 | Ownership of the target bus |
| bus_req | output | 1 | Request for the target bus |
| out_data | output | DATA_W | Word being written out |
| out_valid | output | 1 | `out_data` is valid |
| out_ready | input | 1 | Target takes `out_data` |

## Verification
The bench builds the block with `DEPTH`=4 and `DATA_W`=8. With this depth every fill level can be reached in a few cycles: both banks can be sealed, the second bank can be left part-full, and a third group can wrap back into bank 0. The bench sweeps every burst length from 1 to 2·`DEPTH`+1. Each length runs under several arithmetic grant and ready patterns. The expected output order is the order in which words were pushed. Directed phases then stall both banks, hold a partial bank, and withdraw the grant in the middle of a bank.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

    typedef enum logic [1:0] {
        BANK_EMPTY,
        BANK_FILLING,
        BANK_SEALED
    } bank_state_e;

    typedef enum logic [1:0] {
        DR_IDLE,
        DR_REQUEST,
        DR_STREAM
    } drain_state_e;

endpackage

// File: rtl/wpb_bank.sv
module wpb_bank
    import wpb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [DATA_W-1:0]                      wr_data,
    input  logic                                   wr_last,
    input  logic                                   free,
    input  logic [(DEPTH > 1 ? $clog2(DEPTH) : 1)-1:0] rd_addr,
    output logic [DATA_W-1:0]                      rd_data,
    output logic [$clog2(DEPTH+1)-1:0]             fill_count,
    output bank_state_e                            state,
    output logic                                   seal_now
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    bank_state_e       state_nx;
    logic [CW-1:0]     count_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= BANK_EMPTY;
            fill_count <= '0;
        end else begin
            state      <= state_nx;
            fill_count <= count_nx;
        end
    end

    // next state and seal detection
    always_comb begin
        seal_now = wr_en && (wr_last || (fill_count == CW'(DEPTH - 1)));
        state_nx = state;
        count_nx = fill_count;
        if (free) begin
            state_nx = BANK_EMPTY;
            count_nx = '0;
        end else if (wr_en) begin
            count_nx = fill_count + CW'(1);
            state_nx = seal_now ? BANK_SEALED : BANK_FILLING;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[AW'(fill_count)] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // R5
    no_write_sealed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> state != BANK_SEALED);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CW'(DEPTH));

    // R5
    free_only_sealed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free |-> state == BANK_SEALED);

endmodule

// File: rtl/wpb_drain.sv
module wpb_drain
    import wpb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   bank_sealed,
    input  logic [$clog2(DEPTH+1)-1:0]             bank_count,
    input  logic                                   bus_grant,
    input  logic                                   out_ready,
    output logic                                   bus_req,
    output logic                                   out_valid,
    output logic [(DEPTH > 1 ? $clog2(DEPTH) : 1)-1:0] rd_addr,
    output logic                                   free,
    output logic                                   drain_sel
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    drain_state_e state, state_nx;
    logic         beat;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= DR_IDLE;
            rd_addr   <= '0;
            drain_sel <= 1'b0;
        end else begin
            state <= state_nx;
            if (free) begin
                rd_addr   <= '0;
                drain_sel <= ~drain_sel;
            end else if (beat) begin
                rd_addr <= rd_addr + AW'(1);
            end
        end
    end

    // outputs and transitions
    always_comb begin
        bus_req   = (state != DR_IDLE);
        out_valid = (state == DR_STREAM) && bus_grant;
        beat      = out_valid && out_ready;
        free      = beat && ((CW'(rd_addr) + CW'(1)) == bank_count);
        state_nx  = state;
        unique case (state)
            DR_IDLE:    if (bank_sealed) state_nx = DR_REQUEST;
            DR_REQUEST: if (bus_grant)   state_nx = DR_STREAM;
            DR_STREAM: begin
                if (free)            state_nx = DR_IDLE;
                else if (!bus_grant) state_nx = DR_REQUEST;
            end
            default:                 state_nx = DR_IDLE;
        endcase
    end

    // R4
    stream_needs_sealed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> bank_sealed);

    // R10
    pause_holds_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !out_valid) |=> ($stable(rd_addr) && $stable(drain_sel)));

    // R9
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !free) |=> bus_req);

endmodule

// File: rtl/wpost_dual_bank.sv
module wpost_dual_bank
    import wpb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_stall,
    input  logic              bus_grant,
    output logic              bus_req,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);

    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW     = $clog2(DEPTH + 1);
    localparam int NBANKS = 2;

    bank_state_e       bank_st  [NBANKS];
    logic [CW-1:0]     bank_cnt [NBANKS];
    logic [DATA_W-1:0] bank_rd  [NBANKS];
    logic [NBANKS-1:0] wr_en;
    logic [NBANKS-1:0] seal_now;
    logic [NBANKS-1:0] bank_free;
    logic [AW-1:0]     rd_addr;
    logic              drain_free;
    logic              drain_sel;
    logic              fill_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_sel <= 1'b0;
        end else if (seal_now[fill_sel]) begin
            fill_sel <= ~fill_sel;
        end
    end

    assign in_stall = (bank_st[fill_sel] == BANK_SEALED);

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        assign wr_en[b]     = in_valid && !in_stall && (fill_sel == 1'(b));
        assign bank_free[b] = drain_free && (drain_sel == 1'(b));

        wpb_bank #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_en[b]),
            .wr_data    (in_data),
            .wr_last    (in_last),
            .free       (bank_free[b]),
            .rd_addr    (rd_addr),
            .rd_data    (bank_rd[b]),
            .fill_count (bank_cnt[b]),
            .state      (bank_st[b]),
            .seal_now   (seal_now[b])
        );
    end

    wpb_drain #(
        .DEPTH (DEPTH)
    ) u_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .bank_sealed (bank_st[drain_sel] == BANK_SEALED),
        .bank_count  (bank_cnt[drain_sel]),
        .bus_grant   (bus_grant),
        .out_ready   (out_ready),
        .bus_req     (bus_req),
        .out_valid   (out_valid),
        .rd_addr     (rd_addr),
        .free        (drain_free),
        .drain_sel   (drain_sel)
    );

    assign out_data = bank_rd[drain_sel];

    // R7
    stall_both_sealed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_st[0] == BANK_SEALED && bank_st[1] == BANK_SEALED) |-> (in_stall && wr_en == '0));

    // R5
    no_write_while_freeing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en & bank_free) == '0);

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!bus_req && !out_valid && !in_stall));

endmodule

// File: tb/wpost_dual_bank_test.sv
module wpost_dual_bank_test;

    localparam int DW = 8;
    localparam int D  = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] in_data;
    logic          in_valid;
    logic          in_last;
    logic          in_stall;
    logic          bus_grant;
    logic          bus_req;
    logic [DW-1:0] out_data;
    logic          out_valid;
    logic          out_ready;

    int  checks = 0;
    int  errors = 0;
    int  cyc    = 0;
    int  gmode  = 0;
    logic g_man = 1'b0;
    logic r_man = 1'b1;
    logic [DW-1:0] exp_q [$];

    always #10 clk = ~clk;   // 50 MHz

    always @(negedge clk) cyc++;

    assign bus_grant = (gmode == 0) ? g_man :
                       (gmode == 1) ? 1'b1 :
                       (gmode == 2) ? ((cyc % 5) != 0) : ((cyc % 7) < 4);
    assign out_ready = (gmode == 0) ? r_man :
                       (gmode == 1) ? ((cyc % 3) != 0) :
                       (gmode == 2) ? 1'b1 : ((cyc % 2) == 0);

    wpost_dual_bank #(.DATA_W(DW), .DEPTH(D)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_stall  (in_stall),
        .bus_grant (bus_grant),
        .bus_req   (bus_req),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // output monitor, sampled mid low phase
    always @(negedge clk) begin
        #5;
        if (rst_n && out_valid) begin
            chk(bus_grant == 1'b1, "R4/R10 valid without grant", int'(bus_grant), 1);
            if (out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected word", int'(out_data), -1);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(out_data == e, "R4 order", int'(out_data), int'(e));
                end
            end
        end
    end

    task automatic push(input logic [DW-1:0] d, input bit last);
        bit s;
        in_valid = 1'b1;
        in_data  = d;
        in_last  = last;
        exp_q.push_back(d);
        s = 1'b1;
        while (s) begin
            #1;
            s = in_stall;
            @(negedge clk);
        end
    endtask

    task automatic idle_in();
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic drain_wait(input string tag);
        int t;
        t = 0;
        while (exp_q.size() > 0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        #1;
        chk(exp_q.size() == 0, {tag, " all words out"}, exp_q.size(), 0);
        chk(bus_req == 1'b0, "R9 request dropped when no bank sealed", int'(bus_req), 0);
        chk(in_stall == 1'b0, "R5 banks reusable after drain", int'(in_stall), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_data  = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(bus_req == 1'b0, "R1 bus_req in reset", int'(bus_req), 0);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(in_stall == 1'b0, "R1 in_stall in reset", int'(in_stall), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!bus_req && !out_valid && !in_stall, "R1 quiet after reset", int'(bus_req), 0);

        // sweep: every burst length, several grant/ready patterns (R2, R8)
        for (int m = 1; m <= 3; m++) begin
            gmode = m;
            for (int n = 1; n <= 2 * D + 1; n++) begin
                for (int i = 0; i < n; i++) push(DW'(n * 16 + i + m), i == n - 1);
                idle_in();
                drain_wait("R8 sweep");
            end
        end

        // both banks sealed without grant (R3, R7, R9)
        gmode = 0;
        g_man = 1'b0;
        r_man = 1'b1;
        for (int i = 0; i < D; i++) push(DW'(8'hA0 + i), 1'b0);
        idle_in();
        repeat (3) @(negedge clk);
        #1;
        chk(bus_req == 1'b1, "R3 request after bank sealed", int'(bus_req), 1);
        chk(out_valid == 1'b0, "R4 no transfer before grant", int'(out_valid), 0);
        for (int i = 0; i < D; i++) push(DW'(8'hB0 + i), 1'b0);
        idle_in();
        repeat (2) @(negedge clk);
        #1;
        chk(in_stall == 1'b1, "R7 stall with both banks sealed", int'(in_stall), 1);
        repeat (4) begin
            @(negedge clk);
            #1;
            chk(bus_req == 1'b1, "R9 request held without grant", int'(bus_req), 1);
        end
        @(negedge clk);
        g_man = 1'b1;
        drain_wait("R2 two full banks");

        // partial second bank waits (R6)
        for (int i = 0; i < D; i++) push(DW'(8'hC0 + i), 1'b0);
        push(8'hC8, 1'b0);
        push(8'hC9, 1'b0);
        idle_in();
        repeat (20) @(negedge clk);
        #1;
        chk(exp_q.size() == 2, "R6 partial bank held", exp_q.size(), 2);
        chk(bus_req == 1'b0, "R6 no request for partial bank", int'(bus_req), 0);
        chk(out_valid == 1'b0, "R6 no transfer of partial bank", int'(out_valid), 0);
        @(negedge clk);
        push(8'hCA, 1'b1);
        idle_in();
        drain_wait("R8 last seals partial bank");

        // grant removed mid-transfer (R10)
        g_man = 1'b0;
        for (int i = 0; i < D; i++) push(DW'(8'hD0 + i), i == D - 1);
        idle_in();
        g_man = 1'b1;
        while (exp_q.size() > D - 2) @(negedge clk);
        g_man = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R10 valid drops with grant", int'(out_valid), 0);
        chk(bus_req == 1'b1, "R10 request kept during pause", int'(bus_req), 1);
        chk(exp_q.size() == D - 2, "R10 no words lost in pause", exp_q.size(), D - 2);
        @(negedge clk);
        g_man = 1'b1;
        drain_wait("R10 resume");

        // target not ready (R11)
        r_man = 1'b0;
        for (int i = 0; i < D; i++) push(DW'(8'hE0 + i), i == D - 1);
        idle_in();
        repeat (5) @(negedge clk);
        #1;
        chk(out_valid == 1'b1, "R11 valid while waiting", int'(out_valid), 1);
        chk(out_data == 8'hE0, "R11 word held", int'(out_data), 8'hE0);
        chk(exp_q.size() == D, "R11 nothing consumed", exp_q.size(), D);
        @(negedge clk);
        r_man = 1'b1;
        drain_wait("R11 release");

        summary();
        $finish;
    end

endmodule